// File: doc/BRIEF.md
# Digital Frequency-Lock Loop Filter

This block is the control loop of a clock generator whose oscillator period is set by a two-part code. The upper part is a divider field and the lower part is a three-bit stage field, so eight stage steps make one octave of period. The block counts cycles of the fast output clock over a measurement window of four base-clock ticks. It compares that count with four times the programmed multiply factor N and moves the code by at most one step per window toward the target.

The correction law has two regimes. When the period error is above 15 percent, the loop runs in coarse mode: it steps once every window, so eight windows move the period by a factor of two, and larger moves are chains of such octaves. At or below 15 percent, the loop runs in fine mode: it steps only while the count lies outside a narrow tolerance, and it holds the code once the count is inside it. Two tolerance hits in a row declare lock. A new N, a new trim seed, a disable or a reset reloads the code from the trim seed and starts the whole process again.

The state machine has five states. `ST_OFF` (disabled, code follows the seed) moves to `ST_ARM` when enabled. `ST_ARM` waits for a base tick and then moves to `ST_COARSE`. At each window end, `ST_COARSE`, `ST_FINE` and `ST_LOCKED` go to `ST_COARSE` if the error is large. Otherwise they go to `ST_LOCKED` if this window and the previous one were both in tolerance, and to `ST_FINE` in every other case. From any state, a parameter change forces `ST_ARM` and a low enable forces `ST_OFF`.

Top module: `fll_loop_filter`

## Requirements
- R1: After arming, a window spans four base ticks; the arming tick opens it, and the fourth following tick closes it and at once opens the next. The count is the number of fast-clock cycles between the opening and closing ticks.
- R2: With count C and target T = 4*N: C > T steps the code up by one (longer period), C < T steps it down by one; the code is {divider, stage}, stage in the low three bits.
- R3: When 20*|C-T| > 3*T, the window is coarse: the mode output is 1 and the code steps by one.
- R4: When 20*|C-T| <= 3*T, the window is fine: the mode output is 0, and the code steps by one only if 32*|C-T| > T, otherwise it holds.
- R5: The code changes only at a window close, by at most one step; it never changes inside a window.
- R6: Stepping the stage past 7 or below 0 wraps it and carries into or borrows from the divider.
- R7: The code saturates at all ones and at all zeros and never wraps around its full range.
- R8: The lock output rises at the close of the second consecutive window with 32*|C-T| <= T, stays high while windows remain in tolerance, and is never high together with coarse mode.
- R9: A change of N or of the trim seed clears lock, sets coarse mode, reloads the code from the seed within one cycle, and waits for a new arming tick.
- R10: While enable is low, lock is 0 and the code follows the trim seed; raising enable starts a fresh settling run.
- R11: During reset, the code is zero, lock is 0 and the mode output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast output clock that the loop measures |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Loop enable; low holds the loop off |
| base_tick | input | 1 | One-cycle pulse per base-clock period, already synchronous to clk |
| mult_n | input | N_W | Multiply factor N |
| trim_seed | input | DIV_W+STG_W | Starting code loaded on every restart |
| div_code | output | DIV_W | Divider field of the period code |
| stg_code | output | STG_W | Stage field of the period code |
| coarse_mode | output | 1 | 1 while in the coarse regime or not yet measuring |
| locked | output | 1 | Lock indication |

## Verification
The bench uses the default parameters: an 11-bit N, a 3-bit divider with a 3-bit stage, a tolerance shift of 5 and four ticks per window. It drives base ticks from a behavioural oscillator whose base period, counted in fast cycles, falls by about 2^(1/8) per code step. The 11-bit N reaches targets of 8000 cycles, larger than any count the oscillator can produce, which drives the code into its lower stop. N = 1 drives it into its upper stop. Targets of 32 and 40 let coarse steps, fine steps, the stage-to-divider carry and lock all appear within a few windows.

// File: rtl/fll_pkg.sv
package fll_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_ARM,
        ST_COARSE,
        ST_FINE,
        ST_LOCKED
    } fll_state_t;
endpackage

// File: rtl/fll_window_timer.sv
module fll_window_timer #(
    parameter int CNT_W     = 15,
    parameter int WIN_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    output logic             win_done,
    output logic [CNT_W-1:0] win_count
);
    localparam int TC_W = $clog2(WIN_TICKS);
    localparam logic [TC_W-1:0] LAST_TICK = TC_W'(WIN_TICKS - 1);

    logic [CNT_W-1:0] cyc_q;
    logic [TC_W-1:0]  tcnt_q;

    assign win_done  = run && tick && (tcnt_q == LAST_TICK);
    assign win_count = (cyc_q == '1) ? cyc_q : cyc_q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            tcnt_q <= '0;
        end else if (!run || win_done) begin
            cyc_q  <= '0;
            tcnt_q <= '0;
        end else begin
            if (cyc_q != '1) cyc_q <= cyc_q + CNT_W'(1);
            if (tick)        tcnt_q <= tcnt_q + TC_W'(1);
        end
    end
endmodule

// File: rtl/fll_error_eval.sv
module fll_error_eval #(
    parameter int CNT_W     = 15,
    parameter int N_W       = 11,
    parameter int TOL_SHIFT = 5,
    parameter int WIN_TICKS = 4
) (
    input  logic [CNT_W-1:0] win_count,
    input  logic [N_W-1:0]   mult_n,
    output logic             too_fast,
    output logic             coarse,
    output logic             in_tol
);
    localparam int W = CNT_W + TOL_SHIFT + 6;

    logic [W-1:0] meas, tgt, diff;

    always_comb begin
        meas     = W'(win_count);
        tgt      = W'(mult_n) * W'(WIN_TICKS);
        too_fast = meas > tgt;
        diff     = too_fast ? (meas - tgt) : (tgt - meas);
        coarse   = (diff * W'(20)) > (tgt * W'(3));
        in_tol   = (diff << TOL_SHIFT) <= tgt;
    end
endmodule

// File: rtl/fll_code_stepper.sv
module fll_code_stepper #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] seed,
    input  logic              step,
    input  logic              up,
    output logic [CODE_W-1:0] code
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
        end else if (load) begin
            code <= seed;
        end else if (step) begin
            if (up && code != '1)
                code <= code + CODE_W'(1);
            else if (!up && code != '0)
                code <= code - CODE_W'(1);
        end
    end
endmodule

// File: rtl/fll_loop_filter.sv
module fll_loop_filter
    import fll_pkg::*;
#(
    parameter int N_W       = 11,
    parameter int DIV_W     = 3,
    parameter int STG_W     = 3,
    parameter int TOL_SHIFT = 5,
    parameter int WIN_TICKS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   base_tick,
    input  logic [N_W-1:0]         mult_n,
    input  logic [DIV_W+STG_W-1:0] trim_seed,
    output logic [DIV_W-1:0]       div_code,
    output logic [STG_W-1:0]       stg_code,
    output logic                   coarse_mode,
    output logic                   locked
);
    localparam int CODE_W = DIV_W + STG_W;
    localparam int CNT_W  = N_W + $clog2(WIN_TICKS) + 2;

    fll_state_t        state_q, state_d;
    logic [N_W-1:0]    n_q;
    logic [CODE_W-1:0] seed_q;
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  win_count;
    logic              param_chg, measuring, load_code, step_code;
    logic              win_done, too_fast, coarse, in_tol, good_q;

    assign param_chg = (mult_n != n_q) || (trim_seed != seed_q);
    assign measuring = (state_q == ST_COARSE) || (state_q == ST_FINE) ||
                       (state_q == ST_LOCKED);
    assign load_code = (state_q == ST_OFF) || param_chg || !en;
    assign step_code = measuring && win_done && !in_tol;

    fll_window_timer #(.CNT_W(CNT_W), .WIN_TICKS(WIN_TICKS)) timer_i (
        .clk(clk), .rst_n(rst_n), .run(measuring), .tick(base_tick),
        .win_done(win_done), .win_count(win_count)
    );

    fll_error_eval #(.CNT_W(CNT_W), .N_W(N_W), .TOL_SHIFT(TOL_SHIFT),
                     .WIN_TICKS(WIN_TICKS)) eval_i (
        .win_count(win_count), .mult_n(mult_n),
        .too_fast(too_fast), .coarse(coarse), .in_tol(in_tol)
    );

    fll_code_stepper #(.CODE_W(CODE_W)) stepper_i (
        .clk(clk), .rst_n(rst_n), .load(load_code), .seed(trim_seed),
        .step(step_code), .up(too_fast), .code(code)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    if (en) state_d = ST_ARM;
            ST_ARM:    if (base_tick) state_d = ST_COARSE;
            ST_COARSE, ST_FINE, ST_LOCKED: begin
                if (win_done) begin
                    if (coarse)                state_d = ST_COARSE;
                    else if (in_tol && good_q) state_d = ST_LOCKED;
                    else                       state_d = ST_FINE;
                end
            end
        endcase
        if (!en)            state_d = ST_OFF;
        else if (param_chg) state_d = ST_ARM;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            n_q     <= '0;
            seed_q  <= '0;
            good_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            n_q     <= mult_n;
            seed_q  <= trim_seed;
            if (!en || param_chg || !measuring) good_q <= 1'b0;
            else if (win_done)                  good_q <= in_tol;
        end
    end

    always_comb begin
        div_code    = code[CODE_W-1:STG_W];
        stg_code    = code[STG_W-1:0];
        locked      = (state_q == ST_LOCKED);
        coarse_mode = !((state_q == ST_FINE) || (state_q == ST_LOCKED));
    end
endmodule

// File: rtl/fll_loop_filter_chk.sv
module fll_loop_filter_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              win_done,
    input logic              in_tol,
    input logic [CODE_W-1:0] code,
    input logic              locked,
    input logic              coarse_mode
);
    AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ({1'b0, code} == {1'b0, $past(code)}) ||
                    ({1'b0, code} == {1'b0, $past(code)} + 1'b1) ||
                    ({1'b0, code} + 1'b1 == {1'b0, $past(code)}));   // R5
    AST_CODE_HELD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !win_done) |=> $stable(code));                     // R5
    AST_RESTART_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !locked);                                           // R9
    AST_LOCK_NOT_COARSE: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !coarse_mode);                                      // R8
    AST_LOCK_FROM_TOL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(win_done && in_tol));                  // R8
    AST_NO_WRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && code == '1) |=> code != '0);                       // R7
    AST_NO_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && code == '0) |=> code != '1);                       // R7
endmodule

bind fll_loop_filter fll_loop_filter_chk #(.CODE_W(DIV_W + STG_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_code), .win_done(win_done),
    .in_tol(in_tol), .code({div_code, stg_code}), .locked(locked),
    .coarse_mode(coarse_mode)
);

// File: tb/fll_loop_filter_tb.sv
module fll_loop_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        base_tick = 1'b0;
    logic [10:0] mult_n = 11'd32;
    logic [5:0]  trim_seed = 6'd36;
    logic [2:0]  div_code, stg_code;
    logic        coarse_mode, locked;

    int checks = 0;
    int errors = 0;
    int exp_code, good_run;
    bit exp_lock, exp_coarse;

    always #4 clk = ~clk;

    fll_loop_filter dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .base_tick(base_tick),
        .mult_n(mult_n), .trim_seed(trim_seed), .div_code(div_code),
        .stg_code(stg_code), .coarse_mode(coarse_mode), .locked(locked)
    );

    function automatic int cur_code();
        return int'({div_code, stg_code});
    endfunction

    // behavioural oscillator: base period in fast cycles shrinks ~2^(1/8) per code step
    function automatic int osc_period(int code);
        int m;
        case (code % 8)
            0: m = 256; 1: m = 235; 2: m = 215; 3: m = 197;
            4: m = 181; 5: m = 166; 6: m = 152; default: m = 140;
        endcase
        return (4 * m) >> (code / 8);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse();
        base_tick = 1'b1;
        @(negedge clk);
        base_tick = 1'b0;
    endtask

    task automatic expect_restart(string req);
        repeat (2) @(negedge clk);
        check(cur_code() == int'(trim_seed), {req, " code reload"}, cur_code(), int'(trim_seed));
        check(!locked, {req, " lock cleared"}, int'(locked), 0);
        check(coarse_mode, {req, " coarse flag"}, int'(coarse_mode), 1);
        exp_code = int'(trim_seed);
        good_run = 0;
    endtask

    task automatic run_windows(int n);
        for (int w = 0; w < n; w++) begin
            int p, c, t, d, start;
            start = cur_code();
            p = osc_period(start);
            repeat (p - 1) @(negedge clk);
            for (int k = 0; k < 3; k++) begin
                pulse();
                repeat (p - 1) @(negedge clk);
            end
            check(cur_code() == start, "R1 R5 code steady inside window", cur_code(), start);
            pulse();
            c = 4 * p;
            t = 4 * int'(mult_n);
            d = (c > t) ? c - t : t - c;
            exp_coarse = (d * 20) > (t * 3);
            if (d * 32 <= t) begin
                good_run++;
            end else begin
                good_run = 0;
                if (c > t && exp_code < 63) exp_code++;
                else if (c < t && exp_code > 0) exp_code--;
            end
            exp_lock = (good_run >= 2);
            check(cur_code() == exp_code, "R2 R3 R4 R6 R7 code after window", cur_code(), exp_code);
            check(coarse_mode == exp_coarse, "R3 R4 mode flag", int'(coarse_mode), int'(exp_coarse));
            check(locked == exp_lock, "R8 lock flag", int'(locked), int'(exp_lock));
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(cur_code() == 0, "R11 code in reset", cur_code(), 0);
        check(!locked, "R11 lock in reset", int'(locked), 0);
        check(coarse_mode, "R11 mode in reset", int'(coarse_mode), 1);
        rst_n = 1'b1;
        expect_restart("R10");
    endtask

    task automatic t_settle();
        pulse();
        run_windows(8);
        check(locked, "R8 locked after settling", int'(locked), 1);
        check(div_code == 3'd5 && stg_code == 3'd0, "R6 carry into divider",
              cur_code(), 40);
    endtask

    task automatic t_new_n();
        mult_n = 11'd40;
        expect_restart("R9 new N");
        pulse();
        run_windows(6);
    endtask

    task automatic t_new_trim();
        trim_seed = 6'd44;
        expect_restart("R9 new trim");
        pulse();
        run_windows(8);
    endtask

    task automatic t_disable();
        en = 1'b0;
        expect_restart("R10 disable");
        trim_seed = 6'd30;
        repeat (2) @(negedge clk);
        check(cur_code() == 30, "R10 code follows seed while off", cur_code(), 30);
        check(!locked, "R10 no lock while off", int'(locked), 0);
        en = 1'b1;
        expect_restart("R10 re-enable");
        pulse();
        run_windows(5);
    endtask

    task automatic t_sat_high();
        mult_n = 11'd1;
        trim_seed = 6'd61;
        expect_restart("R9 seed 61");
        pulse();
        run_windows(5);
        check(cur_code() == 63, "R7 upper stop", cur_code(), 63);
    endtask

    task automatic t_sat_low();
        mult_n = 11'd2000;
        trim_seed = 6'd1;
        expect_restart("R9 seed 1");
        pulse();
        run_windows(3);
        check(cur_code() == 0, "R7 lower stop", cur_code(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_settle();
        t_new_n();
        t_new_trim();
        t_disable();
        t_sat_high();
        t_sat_low();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule